// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM of 1024 words by 4 bits. The host hands over one request at a time through a valid/ready handshake: an address, a write flag and, for writes, a 4-bit data word. The sequencer turns each request into a properly shaped cycle on the memory pins. It drives an active-low chip select, an active-low write enable and a 10-bit address, and it controls the shared data bus through a separate output-enable, an outgoing data word and an incoming data word. The tri-state pad itself sits outside the block.

Every analog timing figure of the memory is a parameter in nanoseconds, and so is the clock period. At elaboration the block rounds each figure up to a whole number of clock cycles, with a floor of one cycle. These figures are the access time, write pulse width, address-valid-to-end-of-write, data setup, address hold, bus release time and cycle time. The read phase, the write pulse, the write hold and the read-to-idle turnaround each last the resulting count. Between accesses the chip select rests high, so the memory sits in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, `mem_cs_n` and `mem_we_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1. A reset in the middle of an access abandons that access.
- R2: `req_ready` is 1 only while the block is idle, and a request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `mem_cs_n` is 1 whenever no access is in progress.
- R3: A read drives `mem_cs_n` low with `mem_we_n` high and `mem_addr` equal to the request address for RD_CYC cycles, which is 2 at the default 20 ns clock. It samples `mem_dq_in` on the last rising edge of that window. On the next cycle `rsp_valid` is 1 for exactly one cycle, with `rsp_rdata` holding the sampled word, and `mem_cs_n` is high again.
- R4: A write pulls `mem_cs_n` and `mem_we_n` low together, with the request address on `mem_addr`, for WP_CYC cycles (2 at defaults). Both then rise on the same edge, so either one ends the write.
- R5: `mem_dq_oe` rises only after `mem_we_n` has been low for at least one full cycle. It is never 1 while `mem_cs_n` is low and `mem_we_n` is high.
- R6: `mem_addr` does not change while `mem_we_n` stays low.
- R7: After a read, the block stays busy (`req_ready` 0) for TURN_CYC further cycles (1 at defaults) with chip select high. Only then can it take the next request, so a following write cannot overlap the memory's bus release.
- R8: After a write ends, `mem_dq_oe`, `mem_dq_out` and `mem_addr` stay unchanged for HOLD_CYC cycles (1 at defaults) with chip select high. Then the driver is released and `req_ready` returns to 1.
- R9: Each phase length is the nanosecond figure divided by the clock period, rounded up, and at least 1. WP_CYC is the largest of the pulse width, the address-valid time and one cycle plus the data setup. WP_CYC+HOLD_CYC also covers the cycle time.
- R10: Request fields presented while `req_ready` is 0 are ignored. They do not alter `mem_addr`, `mem_dq_out` or the kind of cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 4 | Read data |
| mem_addr | output | 10 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_oe | output | 1 | Enable for the external data-bus driver |
| mem_dq_out | output | 4 | Data to drive on the bus |
| mem_dq_in | input | 4 | Data read back from the bus |

## Verification
Two things are hard to expose at the ports. One is whether the read sample falls exactly on the edge that satisfies the access time. The other is whether request fields changed during a busy access leak through. The bench's memory model counts how long chip select has been low and returns the inverted word until the access window has elapsed, so an early capture yields wrong data. During every access the bench keeps `req_valid` high with altered address, data and direction, and checks that the bus still carries the values accepted at the start.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACC   = 3'd1,
    ST_RD_TURN  = 3'd2,
    ST_WR_PULSE = 3'd3,
    ST_WR_HOLD  = 3'd4
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned per_ns);
    int unsigned c;
    c = (ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

  // Read window: access time and cycle time both bound it.
  function automatic int unsigned rd_cycles(input int unsigned t_acc,
                                            input int unsigned t_cyc,
                                            input int unsigned per_ns);
    return max2(ns_to_cyc(t_acc, per_ns), ns_to_cyc(t_cyc, per_ns));
  endfunction

  // Write pulse: pulse width, address-valid window, and one undriven cycle
  // followed by the data setup window.
  function automatic int unsigned wp_cycles(input int unsigned t_wp,
                                            input int unsigned t_aw,
                                            input int unsigned t_ds,
                                            input int unsigned per_ns);
    return max3(ns_to_cyc(t_wp, per_ns), ns_to_cyc(t_aw, per_ns),
                1 + ns_to_cyc(t_ds, per_ns));
  endfunction

  // Hold after the write ends: address hold, and the rest of the cycle time.
  function automatic int unsigned hold_cycles(input int unsigned t_ah,
                                              input int unsigned t_cyc,
                                              input int unsigned wp,
                                              input int unsigned per_ns);
    int unsigned rest;
    rest = (ns_to_cyc(t_cyc, per_ns) > wp) ? ns_to_cyc(t_cyc, per_ns) - wp : 1;
    return max3(ns_to_cyc(t_ah, per_ns), rest, 1);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (capture) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else begin
      valid <= strobe;
      if (strobe) dout <= din;
    end
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter int unsigned DW        = 4,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_ACC_NS  = 25,
  parameter int unsigned T_CYC_NS  = 25,
  parameter int unsigned T_WP_NS   = 20,
  parameter int unsigned T_AW_NS   = 20,
  parameter int unsigned T_DS_NS   = 12,
  parameter int unsigned T_AH_NS   = 5,
  parameter int unsigned T_REL_NS  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_dq_oe,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC   = rd_cycles(T_ACC_NS, T_CYC_NS, CLK_NS);
  localparam int unsigned WP_CYC   = wp_cycles(T_WP_NS, T_AW_NS, T_DS_NS, CLK_NS);
  localparam int unsigned HOLD_CYC = hold_cycles(T_AH_NS, T_CYC_NS, WP_CYC, CLK_NS);
  localparam int unsigned TURN_CYC = ns_to_cyc(T_REL_NS, CLK_NS);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(HOLD_CYC, TURN_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

  seq_state_e state_q;
  logic       cs_n_q, we_n_q, oe_q;

  // Named internal events
  logic             t_done;
  logic             ev_accept;
  logic             ev_rd_sample;
  logic             ev_wr_end;
  logic             ev_turn_end;
  logic             ev_hold_end;
  logic             t_load;
  logic [CNT_W-1:0] t_load_val;

  assign req_ready    = (state_q == ST_IDLE);
  assign ev_accept    = req_valid && req_ready;
  assign ev_rd_sample = (state_q == ST_RD_ACC)   && t_done;
  assign ev_wr_end    = (state_q == ST_WR_PULSE) && t_done;
  assign ev_turn_end  = (state_q == ST_RD_TURN)  && t_done;
  assign ev_hold_end  = (state_q == ST_WR_HOLD)  && t_done;

  assign t_load = ev_accept || ev_rd_sample || ev_wr_end;

  always_comb begin
    if (ev_accept)         t_load_val = req_write ? LD_WP : LD_RD;
    else if (ev_rd_sample) t_load_val = LD_TURN;
    else                   t_load_val = LD_HOLD;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_load_val),
    .done     (t_done)
  );

  sram_req_latch #(.AW(AW), .DW(DW)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (ev_accept),
    .addr_in (req_addr),
    .data_in (req_wdata),
    .addr_q  (mem_addr),
    .data_q  (mem_dq_out)
  );

  sram_rd_capture #(.DW(DW)) u_rdcap (
    .clk    (clk),
    .rst    (rst),
    .strobe (ev_rd_sample),
    .din    (mem_dq_in),
    .valid  (rsp_valid),
    .dout   (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            cs_n_q <= 1'b0;
            if (req_write) begin
              we_n_q  <= 1'b0;
              state_q <= ST_WR_PULSE;
            end else begin
              state_q <= ST_RD_ACC;
            end
          end
        end
        ST_RD_ACC: begin
          if (ev_rd_sample) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_RD_TURN;
          end
        end
        ST_RD_TURN: begin
          if (ev_turn_end) state_q <= ST_IDLE;
        end
        ST_WR_PULSE: begin
          oe_q <= 1'b1;
          if (ev_wr_end) begin
            cs_n_q  <= 1'b1;
            we_n_q  <= 1'b1;
            state_q <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (ev_hold_end) begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cs_n  = cs_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_dq_oe = oe_q;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int unsigned AW       = 10,
  parameter int unsigned DW       = 4,
  parameter int unsigned WP_CYC   = 2,
  parameter int unsigned TURN_CYC = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_out,
  input logic          req_ready,
  input logic          rsp_valid
);
  logic        we_q, cs_q;
  logic [15:0] we_run;
  logic [15:0] rd_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b1;
      cs_q   <= 1'b1;
      we_run <= '0;
      rd_gap <= '1;
    end else begin
      we_q   <= we_n;
      cs_q   <= cs_n;
      we_run <= we_n ? 16'd0 : we_run + 16'd1;
      if (cs_n && !cs_q && we_n) rd_gap <= '0;
      else if (rd_gap != '1)     rd_gap <= rd_gap + 16'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cs_n && we_n && !oe && !rsp_valid && req_ready));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> !cs_n);

  // R4
  wp_len_chk: assert property (@(posedge clk) disable iff (rst)
    (we_n && !we_q) |-> (we_run >= 16'(WP_CYC)));

  // R5
  oe_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && !cs_n) |-> !we_n);

  // R5
  oe_late_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (!we_n && $past(!we_n)));

  // R6
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> $stable(addr));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (oe && $past(oe)) |-> ($stable(dq_out) && $stable(addr)));

  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && !we_n) |-> (rd_gap >= 16'(TURN_CYC)));
endmodule

bind sram_seq_ctrl sram_seq_chk #(
  .AW       (AW),
  .DW       (DW),
  .WP_CYC   (WP_CYC),
  .TURN_CYC (TURN_CYC)
) u_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (mem_cs_n),
  .we_n      (mem_we_n),
  .oe        (mem_dq_oe),
  .addr      (mem_addr),
  .dq_out    (mem_dq_out),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;
  localparam int CLK_NS = 20;
  // Bench's own rounding of the default figures (R9)
  localparam int B_RD = ((25 + CLK_NS - 1) / CLK_NS);            // 2
  localparam int B_WP = (((12 + CLK_NS - 1) / CLK_NS) + 1);      // 2

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [9:0] req_addr  = '0;
  logic [3:0] req_wdata = '0;
  logic       rsp_valid;
  logic [3:0] rsp_rdata;
  logic [9:0] mem_addr;
  logic       mem_cs_n, mem_we_n, mem_dq_oe;
  logic [3:0] mem_dq_out;
  logic [3:0] mem_dq_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_seq_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in)
  );

  // Memory model: wrong data until chip select has been low for the access window.
  logic [3:0] mem    [1024];
  logic [3:0] shadow [1024];
  int         rd_low = 0;
  logic [9:0] pend_a;
  logic [3:0] pend_d;
  bit         pend_ok = 0;
  logic       we_prev = 1'b1;

  assign mem_dq_in = (rd_low >= B_RD) ? mem[mem_addr] : ~mem[mem_addr];

  always @(negedge clk) begin
    if (!mem_cs_n && mem_we_n) rd_low = rd_low + 1;
    else                       rd_low = 0;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      pend_a = mem_addr; pend_d = mem_dq_out; pend_ok = 1;
    end
    if (!we_prev && mem_we_n) begin
      if (pend_ok) mem[pend_a] = pend_d;
      pend_ok = 0;
    end
    we_prev = mem_we_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [3:0] d);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before write", int'(req_ready), 1);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);  // after accept edge
    req_write = 0; req_addr = ~a; req_wdata = ~d;  // R10: ignored while busy
    chk(mem_cs_n == 0 && mem_we_n == 0, "R4 cs/we low", {mem_cs_n, mem_we_n}, 0);
    chk(mem_addr == a, "R4 write address", int'(mem_addr), int'(a));
    chk(mem_dq_oe == 0, "R5 driver off first pulse cycle", int'(mem_dq_oe), 0);
    chk(req_ready == 0, "R2 busy during write", int'(req_ready), 0);
    for (int i = 1; i < B_WP; i++) begin
      @(negedge clk);
      chk(mem_we_n == 0 && mem_cs_n == 0, "R4 pulse held", {mem_cs_n, mem_we_n}, 0);
      chk(mem_dq_oe == 1 && mem_dq_out == d, "R5 write data driven", int'(mem_dq_out), int'(d));
      chk(mem_addr == a, "R10 R6 address unaffected", int'(mem_addr), int'(a));
    end
    @(negedge clk);  // hold phase
    req_valid = 0;
    chk(mem_we_n == 1 && mem_cs_n == 1, "R4 cs/we rise together", {mem_cs_n, mem_we_n}, 3);
    chk(mem_dq_oe == 1 && mem_dq_out == d && mem_addr == a, "R8 hold", int'(mem_dq_out), int'(d));
    @(negedge clk);
    chk(mem_dq_oe == 0 && req_ready == 1, "R8 release", {mem_dq_oe, req_ready}, 1);
    shadow[a] = d;
  endtask

  task automatic do_read(input logic [9:0] a);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before read", int'(req_ready), 1);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_write = 1; req_addr = ~a; req_wdata = 4'h5;  // R10: ignored while busy
    chk(mem_cs_n == 0 && mem_we_n == 1 && mem_dq_oe == 0, "R3 read cycle",
        {mem_cs_n, mem_we_n, mem_dq_oe}, 2);
    chk(mem_addr == a, "R3 read address", int'(mem_addr), int'(a));
    for (int i = 1; i < B_RD; i++) begin
      @(negedge clk);
      chk(mem_cs_n == 0 && rsp_valid == 0, "R3 window", {mem_cs_n, rsp_valid}, 0);
      chk(mem_addr == a && mem_we_n == 1, "R10 read unaffected", int'(mem_addr), int'(a));
    end
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1, "R3 rsp pulse", int'(rsp_valid), 1);
    chk(rsp_rdata == shadow[a], "R3 read data", int'(rsp_rdata), int'(shadow[a]));
    chk(mem_cs_n == 1, "R3 cs released", int'(mem_cs_n), 1);
    chk(req_ready == 0, "R7 turnaround busy", int'(req_ready), 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R3 pulse one cycle", int'(rsp_valid), 0);
    chk(req_ready == 1, "R7 idle after turnaround", int'(req_ready), 1);
  endtask

  typedef logic [14:0] vec_t;  // {write, addr[9:0], data[3:0]}
  localparam vec_t VEC [0:11] = '{
    {1'b1, 10'd0,    4'hA}, {1'b1, 10'd1023, 4'h5}, {1'b0, 10'd0,    4'h0},
    {1'b0, 10'd1023, 4'h0}, {1'b0, 10'd77,   4'h0}, {1'b1, 10'd77,   4'h3},
    {1'b1, 10'd77,   4'hC}, {1'b0, 10'd77,   4'h0}, {1'b1, 10'd512,  4'hF},
    {1'b0, 10'd512,  4'h0}, {1'b1, 10'd300,  4'h0}, {1'b0, 10'd300,  4'h0}
  };

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]    = 4'((i * 7 + 3) & 15);
      shadow[i] = 4'((i * 7 + 3) & 15);
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_cs_n == 1 && mem_we_n == 1 && mem_dq_oe == 0, "R1 reset pins",
        {mem_cs_n, mem_we_n, mem_dq_oe}, 6);
    chk(rsp_valid == 0 && req_ready == 1, "R1 reset host side", {rsp_valid, req_ready}, 1);
    rst = 0;
    @(negedge clk);
    chk(mem_cs_n == 1, "R2 cs high while idle", int'(mem_cs_n), 1);

    for (int v = 0; v < 12; v++) begin
      if (VEC[v][14]) do_write(VEC[v][13:4], VEC[v][3:0]);
      else            do_read(VEC[v][13:4]);
    end

    // R9 R7: read then write back to back, write then read back to back
    do_read(10'd5);
    do_write(10'd5, 4'h9);
    do_read(10'd5);

    // R1: reset in the middle of a write
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 10'd900; req_wdata = 4'h1;
    @(negedge clk);
    req_valid = 0;
    rst = 1;
    @(negedge clk);
    chk(mem_cs_n == 1 && mem_we_n == 1 && mem_dq_oe == 0, "R1 mid-access reset",
        {mem_cs_n, mem_we_n, mem_dq_oe}, 6);
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    rst = 0;
    do_read(10'd900);

    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule